// File: doc/BRIEF.md
# Serial Receive Address-Match Filter

This block sits behind a receiver deserializer that delivers complete words of a configurable data width plus an optional ninth bit. It decides, word by word, whether the word is an address word, whether that address is recognised, and whether the word should be written to the receive buffer. Recognised addresses are swallowed: they raise a pending flag and a one-cycle interrupt request, and they open a forwarding window. Data words are forwarded while the window is open and dropped while it is closed. The window closes again at the next address word that is not recognised.

Two mode bits select how address words are identified and matched. The ninth-bit modes treat any word with the ninth bit set as an address. The break mode treats the first word after a break pulse as the address. A character-search mode does no gating at all and only flags arrivals of the compare character. Software clears the pending flag with a strobe. Any word that completes while the flag is still set is refused and recorded in a sticky overrun flag.

There are two state machines. The gating machine has the states GATE_DROP (reset state; data is discarded) and GATE_PASS (data is forwarded). A recognised address word moves it to GATE_PASS, and any other address word moves it to GATE_DROP. The break machine has the states BRK_IDLE (reset state) and BRK_ARMED. A break pulse moves it to BRK_ARMED, and any completed word without a break moves it back to BRK_IDLE.

Top module: `serial_addr_filter`

## Requirements
- R1: After reset, buf_wr, match_irq, addr_pend and overrun are 0, the gate is in GATE_DROP and the break machine is in BRK_IDLE.
- R2: With mode_sel = 2'b00, a word whose ninth bit is 1 is an address and is always recognised. A word whose ninth bit is 0 is data.
- R3: With mode_sel = 2'b10, a word whose ninth bit is 1 is an address. It is recognised only if its data equals cmp_char.
- R4: With mode_sel = 2'b11, the first word taken while BRK_ARMED is the address, recognised only if it equals cmp_char. A break pulse in the same cycle as a word arms the qualifier for the following word.
- R5: With mode_sel = 2'b01 (character search), every accepted word is written. A word equal to cmp_char also sets addr_pend and pulses match_irq.
- R6: An address word is never written to the buffer. A recognised address sets addr_pend and pulses match_irq for one cycle.
- R7: Data words after a recognised address are written, up to the next address word.
- R8: Data words after an unrecognised address, or after reset before any address, are not written.
- R9: A word arriving while addr_pend is 1 is not written, changes no gating state and sets the sticky overrun flag.
- R10: pend_clr clears addr_pend and overrun. A set in the same cycle wins over the clear.
- R11: buf_wr and buf_data appear in the cycle after word_vld, and buf_data carries that word's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_vld | input | 1 | A received word completes this cycle |
| word_data | input | DATA_W | Data bits of the word |
| word_bit9 | input | 1 | Ninth bit of the word |
| brk_pulse | input | 1 | Break detected |
| cmp_char | input | DATA_W | Compare character |
| mode_sel | input | 2 | Match mode |
| pend_clr | input | 1 | Software clear of addr_pend and overrun |
| buf_wr | output | 1 | Receive buffer write strobe |
| buf_data | output | DATA_W | Data for the buffer |
| addr_pend | output | 1 | Address or character recognised, awaiting clear |
| match_irq | output | 1 | One-cycle recognition interrupt request |
| overrun | output | 1 | Sticky: a word was refused while pending |

## Verification
The bench builds the block with DATA_W = 4. With that width, all sixteen data values, both ninth-bit values and all four modes can be swept exhaustively, so words equal to the compare character occur often. This reaches both recognised and unrecognised addresses, break-qualified words and refused words under pending. Pending clears and break pulses are interleaved arithmetically with the sweep. The resulting sequences pass through every transition of both state machines.

// File: rtl/saf_pkg.sv
package saf_pkg;
    typedef enum logic [1:0] {
        MODE_NINTH      = 2'b00,
        MODE_SEARCH     = 2'b01,
        MODE_NINTH_CHAR = 2'b10,
        MODE_BRK_CHAR   = 2'b11
    } match_mode_e;

    typedef enum logic {
        GATE_DROP = 1'b0,
        GATE_PASS = 1'b1
    } gate_state_e;

    typedef enum logic {
        BRK_IDLE  = 1'b0,
        BRK_ARMED = 1'b1
    } brk_state_e;

    typedef struct packed {
        logic search;
        logic is_addr;
        logic hit;
    } word_class_t;
endpackage

// File: rtl/saf_classify.sv
module saf_classify
    import saf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              bit9,
    input  logic [DATA_W-1:0] cmp,
    input  logic [1:0]        mode,
    input  logic              armed,
    output word_class_t       cls
);
    localparam int CMP_BITS = DATA_W;

    logic [CMP_BITS-1:0] bit_eq;
    logic                eq;

    for (genvar g = 0; g < CMP_BITS; g++) begin : g_cmp
        assign bit_eq[g] = ~(data[g] ^ cmp[g]);
    end
    assign eq = &bit_eq;

    always_comb begin
        cls = '0;
        unique case (match_mode_e'(mode))
            MODE_NINTH: begin
                cls.is_addr = bit9;
                cls.hit     = bit9;
            end
            MODE_SEARCH: begin
                cls.search  = 1'b1;
                cls.hit     = eq;
            end
            MODE_NINTH_CHAR: begin
                cls.is_addr = bit9;
                cls.hit     = bit9 & eq;
            end
            MODE_BRK_CHAR: begin
                cls.is_addr = armed;
                cls.hit     = armed & eq;
            end
        endcase
    end
endmodule

// File: rtl/saf_brk_fsm.sv
module saf_brk_fsm
    import saf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic brk_pulse,
    input  logic word_vld,
    output logic armed
);
    brk_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BRK_IDLE:  if (brk_pulse) st_d = BRK_ARMED;
            BRK_ARMED: if (!brk_pulse && word_vld) st_d = BRK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BRK_IDLE;
        else        st_q <= st_d;
    end

    assign armed = (st_q == BRK_ARMED);

    // R4
    brk_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |=> armed);
endmodule

// File: rtl/saf_gate_fsm.sv
module saf_gate_fsm
    import saf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept,
    input  word_class_t cls,
    output logic        fwd
);
    gate_state_e st_q, st_d;
    logic        addr_evt;

    assign addr_evt = accept && cls.is_addr && !cls.search;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GATE_DROP: if (addr_evt && cls.hit)  st_d = GATE_PASS;
            GATE_PASS: if (addr_evt && !cls.hit) st_d = GATE_DROP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GATE_DROP;
        else        st_q <= st_d;
    end

    assign fwd = (st_q == GATE_PASS);

    // R9
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(fwd));
endmodule

// File: rtl/serial_addr_filter.sv
module serial_addr_filter
    import saf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_bit9,
    input  logic              brk_pulse,
    input  logic [DATA_W-1:0] cmp_char,
    input  logic [1:0]        mode_sel,
    input  logic              pend_clr,
    output logic              buf_wr,
    output logic [DATA_W-1:0] buf_data,
    output logic              addr_pend,
    output logic              match_irq,
    output logic              overrun
);
    word_class_t cls;
    logic        armed;
    logic        fwd;
    logic        accept;
    logic        refuse;
    logic        wr_d;
    logic        set_pend;

    assign accept   = word_vld && !addr_pend;
    assign refuse   = word_vld && addr_pend;
    assign wr_d     = accept && (cls.search || (!cls.is_addr && fwd));
    assign set_pend = accept && cls.hit;

    saf_classify #(.DATA_W(DATA_W)) classify_i (
        .data  (word_data),
        .bit9  (word_bit9),
        .cmp   (cmp_char),
        .mode  (mode_sel),
        .armed (armed),
        .cls   (cls)
    );

    saf_brk_fsm brk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .brk_pulse (brk_pulse),
        .word_vld  (word_vld),
        .armed     (armed)
    );

    saf_gate_fsm gate_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .cls    (cls),
        .fwd    (fwd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_wr    <= 1'b0;
            buf_data  <= '0;
            match_irq <= 1'b0;
            addr_pend <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            buf_wr    <= wr_d;
            match_irq <= set_pend;
            if (wr_d) buf_data <= word_data;
            if (set_pend)      addr_pend <= 1'b1;
            else if (pend_clr) addr_pend <= 1'b0;
            if (refuse)        overrun <= 1'b1;
            else if (pend_clr) overrun <= 1'b0;
        end
    end

    // R11
    wr_follows_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> $past(word_vld));

    // R9
    no_wr_when_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> !$past(addr_pend));

    // R6
    irq_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |-> addr_pend);

    // R9
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(word_vld) && $past(addr_pend)));

    // R10
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_pend) |-> $past(pend_clr));
endmodule

// File: tb/serial_addr_filter_tb_top.sv
`timescale 1ns/1ps
module serial_addr_filter_tb_top;
    localparam int W = 4;
    localparam logic [W-1:0] CMP = 4'hA;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         word_vld = 1'b0;
    logic [W-1:0] word_data = '0;
    logic         word_bit9 = 1'b0;
    logic         brk_pulse = 1'b0;
    logic [1:0]   mode_sel = 2'b00;
    logic         pend_clr = 1'b0;
    logic         buf_wr;
    logic [W-1:0] buf_data;
    logic         addr_pend;
    logic         match_irq;
    logic         overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic m_pend = 0, m_ovr = 0, m_fwd = 0, m_arm = 0;

    always #2 clk = ~clk;

    serial_addr_filter #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_data(word_data),
        .word_bit9(word_bit9), .brk_pulse(brk_pulse), .cmp_char(CMP),
        .mode_sel(mode_sel), .pend_clr(pend_clr), .buf_wr(buf_wr),
        .buf_data(buf_data), .addr_pend(addr_pend), .match_irq(match_irq),
        .overrun(overrun)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic step(input logic v, input logic b9, input logic [W-1:0] d,
                        input logic brk, input logic clr);
        logic acc, ia, h, srch, e_wr, e_irq, e_pend, e_ovr;
        string tag, wtag;
        acc  = v && !m_pend;
        srch = (mode_sel == 2'b01);
        ia = 0; h = 0;
        case (mode_sel)
            2'b00: begin ia = b9;    h = b9; end
            2'b01: begin ia = 0;     h = (d == CMP); end
            2'b10: begin ia = b9;    h = b9 && (d == CMP); end
            default: begin ia = m_arm; h = m_arm && (d == CMP); end
        endcase
        e_wr   = acc && (srch || (!ia && m_fwd));
        e_irq  = acc && h;
        e_pend = e_irq ? 1'b1 : (clr ? 1'b0 : m_pend);
        e_ovr  = (v && m_pend) ? 1'b1 : (clr ? 1'b0 : m_ovr);
        if (!v)               tag = "R10";
        else if (m_pend)      tag = "R9";
        else if (srch)        tag = "R5";
        else if (ia)          tag = (mode_sel == 2'b00) ? "R2" : (mode_sel == 2'b10) ? "R3" : "R4";
        else                  tag = m_fwd ? "R7" : "R8";
        wtag = (acc && ia && !srch) ? "R6" : tag;
        word_vld = v; word_bit9 = b9; word_data = d; brk_pulse = brk; pend_clr = clr;
        @(posedge clk);
        @(negedge clk);
        word_vld = 0; brk_pulse = 0; pend_clr = 0;
        check(wtag, "buf_wr", int'(buf_wr), int'(e_wr));
        if (e_wr) check("R11", "buf_data", int'(buf_data), int'(d));
        check(tag, "match_irq", int'(match_irq), int'(e_irq));
        check(tag, "addr_pend", int'(addr_pend), int'(e_pend));
        check(tag, "overrun", int'(overrun), int'(e_ovr));
        if (acc && ia && !srch) m_fwd = h;
        m_arm  = brk ? 1'b1 : (v ? 1'b0 : m_arm);
        m_pend = e_pend;
        m_ovr  = e_ovr;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "buf_wr", int'(buf_wr), 0);
        check("R1", "match_irq", int'(match_irq), 0);
        check("R1", "addr_pend", int'(addr_pend), 0);
        check("R1", "overrun", int'(overrun), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed: data before any address is dropped (R8), then address hit in mode 10
        mode_sel = 2'b10;
        step(1, 0, 4'h3, 0, 0);
        step(1, 1, CMP, 0, 0);
        step(1, 0, 4'h5, 0, 0);
        step(0, 0, 4'h0, 0, 1);
        step(1, 0, 4'h6, 0, 0);
        step(1, 1, 4'h2, 0, 0);
        step(1, 0, 4'h7, 0, 0);
        // break mode: break with word at the same time arms the next word (R4)
        mode_sel = 2'b11;
        step(1, 0, 4'h1, 1, 0);
        step(1, 0, CMP, 0, 0);
        step(1, 0, 4'h9, 0, 1);
        step(1, 0, 4'h4, 0, 0);
        // set wins over clear (R10)
        mode_sel = 2'b01;
        step(1, 0, CMP, 0, 1);
        step(1, 0, 4'h1, 0, 1);
        // exhaustive sweep
        for (int m = 0; m < 4; m++) begin
            mode_sel = 2'(m);
            for (int rep = 0; rep < 3; rep++)
                for (int d = 0; d < 16; d++)
                    for (int b = 0; b < 2; b++)
                        step(((d * 3 + rep + b) % 7) != 6, b[0], 4'(d),
                             ((d + rep + m) % 5) == 0, ((d + b + rep) % 3) == 0);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule